// File: doc/BRIEF.md
# Receive Frame Length Resolver

This block watches the byte stream a receiver produces once the sync word has been found, and works out how many bytes the current frame holds. Preamble and sync word are never part of that count. A one-cycle frame-start pulse marks each new frame. Received bytes then arrive with a valid strobe. Static configuration inputs choose how the length is found.

Three methods are available:
- **Fixed:** the length is a configured constant.
- **Length field:** the length is read from a field inside the frame. The field can be 1 to 12 bits wide, can start at any bit of its byte, and has a configurable byte order and bit order.
- **Type code:** a short code is read from the frame and looked up in an eight-entry table. Each entry holds an enable bit and a length.

For each frame the block emits exactly one result: either a length with a valid strobe, or a discard flag for a length or type that is not legal. Downstream logic uses the result to bound FIFO storage and to find the position of the CRC.

Top module: `rx_frame_len_resolver`

## Requirements
- R1: `cfg_mode_i` selects the method: 0 = fixed, 1 = length field, 2 = type code, 3 = fixed. In a fixed mode `discard_o` never rises.
- R2: In a fixed mode, `len_vld_o` pulses in the cycle after `frame_start_i`, with `len_o` equal to `cfg_fixed_len_i` (0 to 255).
- R3: Length-field extraction, default byte order:
  - Let n = max(1, ceil((`cfg_lf_pos_i` + `cfg_lf_width_i`) / 8)).
  - The field occupies the n bytes starting at zero-based byte index `cfg_lf_idx_i`. These bytes are assembled with the first byte least significant.
  - The window is shifted right by `cfg_lf_pos_i` (0 to 7) and masked to `cfg_lf_width_i` bits (1 to 12).
  - The result appears in the cycle after the last of those n bytes is accepted.
- R4: With `cfg_lf_big_i`=1, the same n bytes are assembled with the first byte most significant, so `cfg_lf_pos_i` counts from the LSB of the last field byte.
- R5: With `cfg_lf_rev_i`=1, the extracted field is bit-reversed across its `cfg_lf_width_i` bits: bit i takes bit width-1-i.
- R6: With `cfg_lf_has_crc_i`=1 the field value is the length. With 0, `cfg_crc_bytes_i` (0 to 4) is added to it.
- R7: A field value below `cfg_min_len_i` or above `cfg_max_len_i` (both 0 to 4095) raises `discard_o` instead of `len_vld_o`. The comparison uses the value before the CRC bytes are added.
- R8: Type-code mode:
  - The code has `cfg_ty_width_i` bits (0 to 7). It sits at byte index `cfg_ty_idx_i` with its LSB at bit `cfg_ty_pos_i`, in default byte order and bit order.
  - For an enabled code k in 0 to 7, `len_o` is `cfg_ty_len_i[8k+7:8k]`.
  - The result appears in the cycle after the last byte of the code field.
- R9: A code whose bit in `cfg_ty_en_i` is clear, or a code above 7, raises `discard_o` instead of `len_vld_o`.
- R10: Frame-start and result handling:
  - `frame_start_i` clears all partial extraction state. A byte presented in the same cycle as the pulse is ignored.
  - Bytes received when no frame-start has occurred since reset produce no result.
  - Each frame produces at most one result, and none if the frame ends before its field is complete.
- R11: After reset, `len_o`, `len_vld_o` and `discard_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse at the start of a frame |
| byte_vld_i | input | 1 | `byte_i` holds a received byte |
| byte_i | input | 8 | Received frame byte |
| cfg_mode_i | input | 2 | Length method select |
| cfg_fixed_len_i | input | 8 | Length used in fixed mode |
| cfg_lf_idx_i | input | 8 | Byte index of the first length-field byte |
| cfg_lf_pos_i | input | 3 | Bit position of the length-field LSB |
| cfg_lf_width_i | input | 4 | Length-field width in bits |
| cfg_lf_big_i | input | 1 | First field byte is most significant |
| cfg_lf_rev_i | input | 1 | Bit-reverse the length field |
| cfg_lf_has_crc_i | input | 1 | Field value already counts the CRC bytes |
| cfg_crc_bytes_i | input | 3 | CRC size in bytes |
| cfg_min_len_i | input | 12 | Smallest accepted field value |
| cfg_max_len_i | input | 12 | Largest accepted field value |
| cfg_ty_idx_i | input | 8 | Byte index of the type code |
| cfg_ty_pos_i | input | 3 | Bit position of the type-code LSB |
| cfg_ty_width_i | input | 3 | Type-code width in bits |
| cfg_ty_en_i | input | 8 | Enable bit for each type |
| cfg_ty_len_i | input | 64 | Eight 8-bit lengths, one per type |
| len_o | output | 13 | Resolved frame length |
| len_vld_o | output | 1 | One-cycle pulse: `len_o` is valid |
| discard_o | output | 1 | One-cycle pulse: the frame is to be dropped |

## Verification
The main function is driven with random frame contents under random settings of field position, width, byte order, bit order, CRC handling and limits. This separates errors in window assembly from errors in shifting, masking and reversal.

Directed frames use hand-computed values: a 12-bit field that crosses a byte boundary, read in both byte orders; a 4-bit reversed field; and type codes that are enabled, disabled, or out of range. These pin down each decoding path on its own.

Frames that are cut short, followed by a fresh frame-start, show whether partial state leaks from one frame into the next. Stray bytes before any frame-start check that the block stays silent when no frame is open.

// File: rtl/flr_pkg.sv
package flr_pkg;
  typedef enum logic [1:0] {
    LM_FIXED     = 2'd0,
    LM_FIELD     = 2'd1,
    LM_TYPE      = 2'd2,
    LM_FIXED_ALT = 2'd3
  } len_mode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/flr_field_grab.sv
module flr_field_grab #(
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned WIDTH_W = 4,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SPAN    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [2:0]         pos_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               big_i,
  input  logic               rev_i,
  output logic               hit_o,
  output logic [FIELD_W-1:0] field_o
);
  localparam int unsigned CNT_W = IDX_W + 2;
  localparam int unsigned WIN_W = 8 * SPAN;
  localparam int unsigned FB_W  = (FIELD_W > 1) ? $clog2(FIELD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]   cnt_q, off, nbytes, span_bits;
  logic               armed_q, in_field, last;
  logic [7:0]         buf_q [SPAN];
  logic [7:0]         cur   [SPAN];
  logic [WIN_W-1:0]   win, shifted;
  logic [FIELD_W:0]   mask_ext;
  logic [FIELD_W-1:0] raw_f, rev_f;

  always_comb begin
    span_bits = CNT_W'(pos_i) + CNT_W'(width_i) + CNT_W'(7);
    nbytes    = span_bits >> 3;
    if (nbytes == '0) nbytes = CNT_W'(1);
  end

  assign off      = cnt_q - CNT_W'(idx_i);
  assign in_field = armed_q && byte_vld_i && !start_i &&
                    (cnt_q >= CNT_W'(idx_i)) && (off < nbytes);
  assign last     = in_field && (off == nbytes - CNT_W'(1));

  // current byte joins stored ones so the result is ready in the capture cycle
  for (genvar k = 0; k < SPAN; k++) begin : g_cur
    assign cur[k] = (in_field && off == CNT_W'(k)) ? byte_i : buf_q[k];
  end

  always_comb begin
    win = '0;
    for (int k = 0; k < SPAN; k++) begin
      if (CNT_W'(k) < nbytes) begin
        if (big_i)
          win = win | (WIN_W'(cur[k]) << (CNT_W'(8) * (nbytes - CNT_W'(1) - CNT_W'(k))));
        else
          win = win | (WIN_W'(cur[k]) << (8 * k));
      end
    end
  end

  assign shifted  = win >> pos_i;
  assign mask_ext = ((FIELD_W+1)'(1) << width_i) - (FIELD_W+1)'(1);
  assign raw_f    = shifted[FIELD_W-1:0] & mask_ext[FIELD_W-1:0];

  always_comb begin
    rev_f = '0;
    for (int i = 0; i < FIELD_W; i++) begin
      int j;
      j = int'(width_i) - 1 - i;
      if (j >= 0) rev_f[i] = raw_f[FB_W'(j)];
    end
  end

  assign hit_o   = last;
  assign field_o = rev_i ? rev_f : raw_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      for (int k = 0; k < SPAN; k++) buf_q[k] <= '0;
    end else if (start_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      for (int k = 0; k < SPAN; k++) buf_q[k] <= '0;
    end else if (byte_vld_i && armed_q) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      if (in_field) buf_q[off[$clog2(SPAN)-1:0]] <= byte_i;
      if (last) armed_q <= 1'b0;
    end
  end

  AST_GRAB_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o); // R10
endmodule

// File: rtl/flr_type_lut.sv
module flr_type_lut #(
  parameter int unsigned N_TYPES = 8,
  parameter int unsigned CODE_W  = 7,
  parameter int unsigned LEN_W   = 8
) (
  input  logic [CODE_W-1:0]        code_i,
  input  logic [N_TYPES-1:0]       en_i,
  input  logic [N_TYPES*LEN_W-1:0] len_tab_i,
  output logic                     ok_o,
  output logic [LEN_W-1:0]         len_o
);
  logic [N_TYPES-1:0] sel;

  for (genvar t = 0; t < N_TYPES; t++) begin : g_sel
    assign sel[t] = (code_i == CODE_W'(t)) && en_i[t];
  end

  always_comb begin
    len_o = '0;
    for (int t = 0; t < N_TYPES; t++)
      if (sel[t]) len_o = len_o | len_tab_i[t*LEN_W +: LEN_W];
  end

  assign ok_o = |sel;

  always_comb begin
    AST_LUT_ONEHOT: assert ($onehot0(sel)); // R8
  end
endmodule

// File: rtl/rx_frame_len_resolver.sv
module rx_frame_len_resolver
  import flr_pkg::*;
#(
  parameter int unsigned LF_W      = 12,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned N_TYPES   = 8,
  parameter int unsigned TY_LEN_W  = 8,
  parameter int unsigned TY_CODE_W = 7,
  parameter int unsigned CRC_W     = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_start_i,
  input  logic                      byte_vld_i,
  input  logic [7:0]                byte_i,
  input  logic [1:0]                cfg_mode_i,
  input  logic [7:0]                cfg_fixed_len_i,
  input  logic [IDX_W-1:0]          cfg_lf_idx_i,
  input  logic [2:0]                cfg_lf_pos_i,
  input  logic [3:0]                cfg_lf_width_i,
  input  logic                      cfg_lf_big_i,
  input  logic                      cfg_lf_rev_i,
  input  logic                      cfg_lf_has_crc_i,
  input  logic [CRC_W-1:0]          cfg_crc_bytes_i,
  input  logic [LF_W-1:0]           cfg_min_len_i,
  input  logic [LF_W-1:0]           cfg_max_len_i,
  input  logic [IDX_W-1:0]          cfg_ty_idx_i,
  input  logic [2:0]                cfg_ty_pos_i,
  input  logic [2:0]                cfg_ty_width_i,
  input  logic [N_TYPES-1:0]        cfg_ty_en_i,
  input  logic [N_TYPES*TY_LEN_W-1:0] cfg_ty_len_i,
  output logic [LF_W:0]             len_o,
  output logic                      len_vld_o,
  output logic                      discard_o
);
  localparam int unsigned OUT_W = LF_W + 1;

  len_mode_e mode;
  logic is_fixed;
  logic lf_hit, ty_hit, ty_ok;
  logic [LF_W-1:0] lf_val;
  logic [TY_CODE_W-1:0] ty_code;
  logic [TY_LEN_W-1:0] ty_len;
  logic lf_bad;
  logic [OUT_W-1:0] lf_len;
  logic res_seen_q;

  assign mode     = len_mode_e'(cfg_mode_i);
  assign is_fixed = (mode == LM_FIXED) || (mode == LM_FIXED_ALT);

  flr_field_grab #(
    .FIELD_W(LF_W), .WIDTH_W(4), .IDX_W(IDX_W), .SPAN(3)
  ) u_len_grab (
    .clk_i, .rst_ni,
    .start_i   (frame_start_i),
    .byte_vld_i,
    .byte_i,
    .idx_i     (cfg_lf_idx_i),
    .pos_i     (cfg_lf_pos_i),
    .width_i   (cfg_lf_width_i),
    .big_i     (cfg_lf_big_i),
    .rev_i     (cfg_lf_rev_i),
    .hit_o     (lf_hit),
    .field_o   (lf_val)
  );

  flr_field_grab #(
    .FIELD_W(TY_CODE_W), .WIDTH_W(4), .IDX_W(IDX_W), .SPAN(2)
  ) u_type_grab (
    .clk_i, .rst_ni,
    .start_i   (frame_start_i),
    .byte_vld_i,
    .byte_i,
    .idx_i     (cfg_ty_idx_i),
    .pos_i     (cfg_ty_pos_i),
    .width_i   ({1'b0, cfg_ty_width_i}),
    .big_i     (1'b0),
    .rev_i     (1'b0),
    .hit_o     (ty_hit),
    .field_o   (ty_code)
  );

  flr_type_lut #(
    .N_TYPES(N_TYPES), .CODE_W(TY_CODE_W), .LEN_W(TY_LEN_W)
  ) u_type_lut (
    .code_i    (ty_code),
    .en_i      (cfg_ty_en_i),
    .len_tab_i (cfg_ty_len_i),
    .ok_o      (ty_ok),
    .len_o     (ty_len)
  );

  assign lf_bad = (lf_val < cfg_min_len_i) || (lf_val > cfg_max_len_i);
  assign lf_len = OUT_W'(lf_val) + (cfg_lf_has_crc_i ? '0 : OUT_W'(cfg_crc_bytes_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o     <= '0;
      len_vld_o <= 1'b0;
      discard_o <= 1'b0;
    end else begin
      len_vld_o <= 1'b0;
      discard_o <= 1'b0;
      if (frame_start_i && is_fixed) begin
        len_vld_o <= 1'b1;
        len_o     <= OUT_W'(cfg_fixed_len_i);
      end else if (lf_hit && mode == LM_FIELD) begin
        len_vld_o <= !lf_bad;
        discard_o <= lf_bad;
        len_o     <= lf_len;
      end else if (ty_hit && mode == LM_TYPE) begin
        len_vld_o <= ty_ok;
        discard_o <= !ty_ok;
        len_o     <= OUT_W'(ty_len);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            res_seen_q <= 1'b0;
    else if (frame_start_i) res_seen_q <= 1'b0;
    else if (len_vld_o || discard_o) res_seen_q <= 1'b1;
  end

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_vld_o || discard_o) |-> !res_seen_q); // R10
  AST_FIXED_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && is_fixed) |=> (len_vld_o && len_o == OUT_W'($past(cfg_fixed_len_i)))); // R2
  AST_FIXED_NO_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_fixed |-> !discard_o); // R1
  AST_FIELD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_vld_o && mode == LM_FIELD) |->
      (len_o >= OUT_W'(cfg_min_len_i) &&
       len_o <= OUT_W'(cfg_max_len_i) + OUT_W'(cfg_crc_bytes_i))); // R7
  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(len_vld_o && discard_o)); // R9
endmodule

// File: tb/rx_frame_len_resolver_tb_top.sv
`timescale 1ns/1ps
module rx_frame_len_resolver_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        frame_start = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_d = '0;
  logic [1:0]  mode = '0;
  logic [7:0]  fixed_len = '0;
  logic [7:0]  lf_idx = '0;
  logic [2:0]  lf_pos = '0;
  logic [3:0]  lf_w = 4'd8;
  logic        lf_big = 1'b0, lf_rev = 1'b0, lf_crc = 1'b1;
  logic [2:0]  crc_b = '0;
  logic [11:0] min_l = '0, max_l = 12'hfff;
  logic [7:0]  ty_idx = '0;
  logic [2:0]  ty_pos = '0, ty_w = 3'd3;
  logic [7:0]  ty_en = '0;
  logic [63:0] ty_len = '0;
  logic [12:0] len_o;
  logic        len_vld, discard;

  rx_frame_len_resolver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .cfg_mode_i(mode), .cfg_fixed_len_i(fixed_len),
    .cfg_lf_idx_i(lf_idx), .cfg_lf_pos_i(lf_pos), .cfg_lf_width_i(lf_w),
    .cfg_lf_big_i(lf_big), .cfg_lf_rev_i(lf_rev), .cfg_lf_has_crc_i(lf_crc),
    .cfg_crc_bytes_i(crc_b), .cfg_min_len_i(min_l), .cfg_max_len_i(max_l),
    .cfg_ty_idx_i(ty_idx), .cfg_ty_pos_i(ty_pos), .cfg_ty_width_i(ty_w),
    .cfg_ty_en_i(ty_en), .cfg_ty_len_i(ty_len),
    .len_o(len_o), .len_vld_o(len_vld), .discard_o(discard));

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int mon_cnt = 0, mon_cyc = 0, mon_len = 0, mon_disc = 0;
  logic [7:0] fr [32];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (len_vld || discard) begin
      mon_cnt  <= mon_cnt + 1;
      mon_cyc  <= cyc;
      mon_len  <= int'(len_o);
      mon_disc <= discard ? 1 : 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int grab(input int idx, input int pos, input int w, input bit big, input bit rev, output int last);
    int n, win, raw, v;
    n = (pos + w + 7) / 8;
    if (n < 1) n = 1;
    last = idx + n - 1;
    win = 0;
    for (int k = 0; k < n; k++)
      win = win | (int'(fr[idx+k]) << (big ? 8*(n-1-k) : 8*k));
    raw = (win >> pos) & ((1 << w) - 1);
    v = raw;
    if (rev) begin
      v = 0;
      for (int i = 0; i < w; i++) if (((raw >> (w-1-i)) & 1) != 0) v = v | (1 << i);
    end
    return v;
  endfunction

  task automatic model(input int nb, output int e_cnt, output int e_disc, output int e_len, output int e_last);
    int v;
    e_disc = 0; e_len = 0; e_last = -1;
    if (mode == 2'd1) begin
      v = grab(int'(lf_idx), int'(lf_pos), int'(lf_w), lf_big, lf_rev, e_last);
      e_disc = (v < int'(min_l) || v > int'(max_l)) ? 1 : 0;
      e_len  = v + (lf_crc ? 0 : int'(crc_b));
    end else if (mode == 2'd2) begin
      v = grab(int'(ty_idx), int'(ty_pos), int'(ty_w), 1'b0, 1'b0, e_last);
      e_disc = (v > 7) ? 1 : (ty_en[v] ? 0 : 1);
      e_len  = (v > 7) ? 0 : int'(ty_len[v*8 +: 8]);
    end else begin
      e_len = int'(fixed_len);
    end
    e_cnt = (e_last < nb) ? 1 : 0;
  endtask

  task automatic run_frame(input int nb, input int e_cnt, input int e_disc, input int e_len,
                           input int e_last, input string req);
    int s;
    @(negedge clk);
    s = cyc; mon_cnt = 0;
    frame_start = 1'b1; byte_vld = 1'b0;
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      frame_start = 1'b0; byte_vld = 1'b1; byte_d = fr[k];
    end
    @(negedge clk);
    frame_start = 1'b0; byte_vld = 1'b0;
    repeat (4) @(negedge clk);
    check(mon_cnt == e_cnt, (e_cnt == 0) ? "R10" : req, "result count", mon_cnt, e_cnt);
    if (e_cnt == 1 && mon_cnt == 1) begin
      check(mon_cyc == s + 2 + e_last, req, "result cycle", mon_cyc - s, 2 + e_last);
      check(mon_disc == e_disc, (e_disc != 0) ? ((mode == 2'd1) ? "R7" : "R9") : req,
            "discard", mon_disc, e_disc);
      if (e_disc == 0) check(mon_len == e_len, req, "length", mon_len, e_len);
    end
  endtask

  task automatic auto_frame(input int nb, input string req);
    int c, d, l, t;
    model(nb, c, d, l, t);
    run_frame(nb, c, d, l, t, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 32; k++) fr[k] = 8'(k * 37 + 5);
    repeat (3) @(negedge clk);
    check(len_o == 0 && !len_vld && !discard, "R11", "reset outputs", int'(len_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // bytes with no frame open
    mode = 2'd1; lf_idx = 0; lf_w = 4'd8; mon_cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); byte_vld = 1'b1; byte_d = 8'h55;
    end
    @(negedge clk); byte_vld = 1'b0;
    repeat (3) @(negedge clk);
    check(mon_cnt == 0, "R10", "stray bytes result count", mon_cnt, 0);

    // fixed modes
    mode = 2'd0; fixed_len = 8'd255; run_frame(4, 1, 0, 255, -1, "R2");
    mode = 2'd3; fixed_len = 8'd0;   run_frame(2, 1, 0, 0, -1, "R1");

    // 12-bit field crossing bytes: fr1=A5 fr2=3C
    fr[1] = 8'hA5; fr[2] = 8'h3C;
    mode = 2'd1; lf_idx = 1; lf_pos = 4; lf_w = 4'd12; lf_big = 0; lf_rev = 0; lf_crc = 1;
    run_frame(8, 1, 0, 970, 2, "R3");
    lf_big = 1; run_frame(8, 1, 0, 2643, 2, "R4");
    // reversed 4-bit 1011 -> 1101, plus CRC
    fr[0] = 8'h0B; lf_idx = 0; lf_pos = 0; lf_w = 4'd4; lf_big = 0; lf_rev = 1;
    lf_crc = 0; crc_b = 3'd2;
    run_frame(8, 1, 0, 15, 0, "R5");
    lf_rev = 0; run_frame(8, 1, 0, 13, 0, "R6");
    min_l = 12'd12; run_frame(8, 1, 1, 0, 0, "R7");
    min_l = 0; max_l = 12'd10; run_frame(8, 1, 1, 0, 0, "R7");
    max_l = 12'hfff;
    // far field index
    fr[20] = 8'h2C; lf_idx = 20; lf_w = 4'd8; lf_crc = 1;
    run_frame(24, 1, 0, 44, 20, "R3");
    // truncated frame, then a fresh one
    lf_idx = 1; lf_pos = 4; lf_w = 4'd12;
    run_frame(2, 0, 0, 0, 2, "R10");
    fr[1] = 8'h00; fr[2] = 8'h01;
    run_frame(8, 1, 0, 16, 2, "R10");

    // type codes
    mode = 2'd2; fr[0] = 8'hE0; ty_idx = 0; ty_pos = 3'd5; ty_w = 3'd3;
    ty_en = 8'h80; ty_len = 64'd200 << 56;
    run_frame(4, 1, 0, 200, 0, "R8");
    ty_en = 8'h7F; run_frame(4, 1, 1, 0, 0, "R9");
    fr[0] = 8'hF0; ty_pos = 3'd4; ty_w = 3'd4; ty_en = 8'hFF;
    run_frame(4, 1, 1, 0, 0, "R9");

    // random mix
    for (int it = 0; it < 160; it++) begin
      int nb;
      for (int k = 0; k < 32; k++) fr[k] = 8'($urandom);
      mode      = 2'($urandom);
      fixed_len = 8'($urandom);
      lf_idx    = 8'($urandom_range(7, 0));
      lf_pos    = 3'($urandom);
      lf_w      = 4'($urandom_range(12, 1));
      lf_big    = 1'($urandom);
      lf_rev    = 1'($urandom);
      lf_crc    = 1'($urandom);
      crc_b     = 3'($urandom_range(4, 0));
      min_l     = 12'($urandom_range(600, 0));
      max_l     = min_l + 12'($urandom_range(3000, 0));
      ty_idx    = 8'($urandom_range(7, 0));
      ty_pos    = 3'($urandom);
      ty_w      = 3'($urandom_range(5, 0));
      ty_en     = 8'($urandom);
      for (int t = 0; t < 8; t++) ty_len[t*8 +: 8] = 8'($urandom_range(240, 0));
      nb = ($urandom_range(9, 0) < 2) ? int'($urandom_range(10, 1)) : 24;
      case (mode)
        2'd0:    auto_frame(nb, "R2");
        2'd1:    auto_frame(nb, lf_big ? "R4" : (lf_rev ? "R5" : "R3"));
        2'd2:    auto_frame(nb, "R8");
        default: auto_frame(nb, "R1");
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule